// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block picks the address of the next instruction for a 32-bit machine whose instructions are 4 bytes long. Every cycle with a valid request it receives the current program counter, a small code naming the kind of control-flow instruction, the raw offset field from the instruction word, the value of the register that a conditional branch tests, the register value that a register jump uses as its target, and the comparison bit of the floating-point status. One cycle later it reports the next program counter, whether control flow left the sequential path, whether a return address must be written, which register receives it, and that return address.

Branches test a register for zero or nonzero, or test the floating-point comparison bit for true or false. They use a 16-bit signed byte offset. Relative jumps use a 26-bit signed byte offset. Register jumps take their full target from a register and flag a target that is not word aligned. Every relative displacement is added to the address of the following instruction.

Top module: `npc_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_valid, taken, link_we and misaligned are all 0.
- R2: Kind code 0 (sequential), and every kind code above 8, gives next_pc = pc + 4 with taken, link_we and misaligned all 0.
- R3: Kind code 1 (branch on zero) is taken only when test_val is zero. When taken, next_pc = pc + 4 + the sign-extension of offset[15:0]. Bits 25:16 of the offset have no effect on any branch.
- R4: Kind code 2 (branch on nonzero) is taken only when test_val is nonzero. It uses the same target rule as R3.
- R5: Kind code 3 is taken when fp_flag is 1, and kind code 4 is taken when fp_flag is 0. Both use the target rule of R3.
- R6: Kind code 5 (relative jump) is always taken, with next_pc = pc + 4 + the sign-extension of offset[25:0]. It does not write a link.
- R7: Kind code 6 (relative jump with link) follows R6 for next_pc. It also sets link_we = 1, with link_idx = 31 and link_val = pc + 4.
- R8: Kind code 7 (register jump) and kind code 8 (register jump with link) are always taken, with next_pc = reg_target. Code 8 also writes link_val = pc + 4 to register 31, and code 7 writes no link.
- R9: misaligned is 1 exactly when a kind 7 or kind 8 request has reg_target[1:0] nonzero. It is never 1 for other kinds.
- R10: A branch that is not taken gives next_pc = pc + 4 with taken = 0 and link_we = 0.
- R11: The outputs for a request appear in the cycle after in_valid is sampled high. A cycle with in_valid low gives out_valid = 0 and taken = link_we = misaligned = 0 one cycle later.
- R12: All address sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A request is present this cycle |
| pc | input | 32 | Address of the current instruction |
| kind | input | 4 | Control-flow kind code (see requirements) |
| offset | input | 26 | Raw offset field; the low 16 bits are used for branches |
| test_val | input | 32 | Register value tested by zero/nonzero branches |
| reg_target | input | 32 | Target address for register jumps |
| fp_flag | input | 1 | Floating-point comparison status bit |
| out_valid | output | 1 | Result of the previous cycle's request is valid |
| next_pc | output | 32 | Address of the next instruction |
| taken | output | 1 | Control flow left the sequential path |
| link_we | output | 1 | Write link_val to register link_idx |
| link_idx | output | 5 | Link destination register, always 31 |
| link_val | output | 32 | Return address pc + 4 |
| misaligned | output | 1 | Register jump target is not word aligned |

## Verification
Each branch kind is driven with its condition both true and false. This separates the taken target from the fall-through address and catches swapped polarity between the zero and nonzero tests and between the two floating-point tests. Negative offsets and offsets with their upper field bits set show whether the branch path sign-extends from bit 15 while the jump path uses all 26 bits. Register jumps with aligned and unaligned targets, with and without link, show that the alignment flag and the link write depend only on the kind. A program counter at the top of the address space, and a cycle with no request, cover address wraparound and output gating.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [3:0] {
    FK_SEQ   = 4'd0,
    FK_BZ    = 4'd1,
    FK_BNZ   = 4'd2,
    FK_BFT   = 4'd3,
    FK_BFF   = 4'd4,
    FK_JMP   = 4'd5,
    FK_JMPL  = 4'd6,
    FK_JREG  = 4'd7,
    FK_JREGL = 4'd8
  } flow_kind_e;

  typedef struct packed {
    logic take;
    logic reg_jump;
    logic link;
    logic long_off;
  } flow_dec_t;

endpackage

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [3:0]      kind_i,
  input  logic [XLEN-1:0] test_val_i,
  input  logic            fp_flag_i,
  output flow_dec_t       dec_o
);

  logic reg_is_zero;

  function automatic logic all_zero(input logic [XLEN-1:0] v);
    return (v == '0);
  endfunction

  assign reg_is_zero = all_zero(test_val_i);

  always_comb begin
    dec_o = '0;
    case (flow_kind_e'(kind_i))
      FK_BZ:    dec_o.take = reg_is_zero;
      FK_BNZ:   dec_o.take = !reg_is_zero;
      FK_BFT:   dec_o.take = fp_flag_i;
      FK_BFF:   dec_o.take = !fp_flag_i;
      FK_JMP:   begin dec_o.take = 1'b1; dec_o.long_off = 1'b1; end
      FK_JMPL:  begin dec_o.take = 1'b1; dec_o.long_off = 1'b1; dec_o.link = 1'b1; end
      FK_JREG:  begin dec_o.take = 1'b1; dec_o.reg_jump = 1'b1; end
      FK_JREGL: begin dec_o.take = 1'b1; dec_o.reg_jump = 1'b1; dec_o.link = 1'b1; end
      default:  dec_o = '0;
    endcase
  end

  // R9
  reg_jump_taken_chk: assert final (!dec_o.reg_jump || dec_o.take);
  // R7
  link_only_taken_chk: assert final (!dec_o.link || dec_o.take);

endmodule

// File: rtl/npc_target.sv
module npc_target #(
  parameter int XLEN       = 32,
  parameter int BOFF_W     = 16,
  parameter int JOFF_W     = 26,
  parameter int INSN_BYTES = 4
) (
  input  logic [XLEN-1:0]   pc_i,
  input  logic [JOFF_W-1:0] offset_i,
  input  logic [XLEN-1:0]   reg_target_i,
  input  logic              long_off_i,
  input  logic              reg_jump_i,
  output logic [XLEN-1:0]   seq_pc_o,
  output logic [XLEN-1:0]   jump_pc_o,
  output logic              unaligned_o
);

  localparam int ALIGN_W = $clog2(INSN_BYTES);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  function automatic logic [XLEN-1:0] sext_short(input logic [BOFF_W-1:0] v);
    return {{(XLEN-BOFF_W){v[BOFF_W-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] sext_long(input logic [JOFF_W-1:0] v);
    return {{(XLEN-JOFF_W){v[JOFF_W-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] wrap_add(input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    return a + b;
  endfunction

  logic [XLEN-1:0] disp;
  logic [XLEN-1:0] rel_pc;

  assign seq_pc_o = wrap_add(pc_i, STEP);
  assign disp     = long_off_i ? sext_long(offset_i) : sext_short(offset_i[BOFF_W-1:0]);
  assign rel_pc   = wrap_add(seq_pc_o, disp);

  generate
    if (ALIGN_W > 0) begin : g_align
      assign unaligned_o = reg_jump_i && (reg_target_i[ALIGN_W-1:0] != '0);
    end else begin : g_noalign
      assign unaligned_o = 1'b0;
    end
  endgenerate

  assign jump_pc_o = reg_jump_i ? reg_target_i : rel_pc;

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int BOFF_W     = 16,
  parameter int JOFF_W     = 26,
  parameter int INSN_BYTES = 4,
  parameter int RIDX_W     = 5,
  parameter int LINK_REG   = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [XLEN-1:0]   pc,
  input  logic [3:0]        kind,
  input  logic [JOFF_W-1:0] offset,
  input  logic [XLEN-1:0]   test_val,
  input  logic [XLEN-1:0]   reg_target,
  input  logic              fp_flag,
  output logic              out_valid,
  output logic [XLEN-1:0]   next_pc,
  output logic              taken,
  output logic              link_we,
  output logic [RIDX_W-1:0] link_idx,
  output logic [XLEN-1:0]   link_val,
  output logic              misaligned
);

  flow_dec_t       dec;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] jump_pc;
  logic            unaligned;
  logic [XLEN-1:0] chosen_pc;

  npc_cond #(.XLEN(XLEN)) u_cond (
    .kind_i     (kind),
    .test_val_i (test_val),
    .fp_flag_i  (fp_flag),
    .dec_o      (dec)
  );

  npc_target #(
    .XLEN(XLEN), .BOFF_W(BOFF_W), .JOFF_W(JOFF_W), .INSN_BYTES(INSN_BYTES)
  ) u_target (
    .pc_i         (pc),
    .offset_i     (offset),
    .reg_target_i (reg_target),
    .long_off_i   (dec.long_off),
    .reg_jump_i   (dec.reg_jump),
    .seq_pc_o     (seq_pc),
    .jump_pc_o    (jump_pc),
    .unaligned_o  (unaligned)
  );

  assign chosen_pc = dec.take ? jump_pc : seq_pc;
  assign link_idx  = RIDX_W'(LINK_REG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      next_pc    <= '0;
      taken      <= 1'b0;
      link_we    <= 1'b0;
      link_val   <= '0;
      misaligned <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      next_pc    <= chosen_pc;
      link_val   <= seq_pc;
      taken      <= in_valid && dec.take;
      link_we    <= in_valid && dec.link;
      misaligned <= in_valid && unaligned;
    end
  end

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!taken && !link_we && !misaligned));

  // R10
  fallthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !taken) |-> (next_pc == link_val && !link_we));

  // R7
  link_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && link_we) |-> (link_val == $past(pc) + XLEN'(INSN_BYTES) && taken));

  // R9
  misaligned_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misaligned |-> (taken && next_pc[1:0] != 2'b00));

  // R11
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

endmodule

// File: tb/tb_npc_unit.sv
module tb_npc_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] pc;
  logic [3:0]  kind;
  logic [25:0] offset;
  logic [31:0] test_val;
  logic [31:0] reg_target;
  logic        fp_flag;
  logic        out_valid;
  logic [31:0] next_pc;
  logic        taken;
  logic        link_we;
  logic [4:0]  link_idx;
  logic [31:0] link_val;
  logic        misaligned;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  npc_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pc(pc), .kind(kind),
    .offset(offset), .test_val(test_val), .reg_target(reg_target),
    .fp_flag(fp_flag), .out_valid(out_valid), .next_pc(next_pc),
    .taken(taken), .link_we(link_we), .link_idx(link_idx),
    .link_val(link_val), .misaligned(misaligned)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Expected next PC written from the requirement text
  function automatic logic [31:0] want_pc(input logic [3:0] k, input logic [31:0] p,
      input logic [25:0] o, input logic [31:0] t, input logic [31:0] r, input logic f);
    logic [31:0] fall;
    logic [31:0] br;
    logic [31:0] jp;
    fall = p + 32'd4;
    br   = fall + {{16{o[15]}}, o[15:0]};
    jp   = fall + {{6{o[25]}}, o};
    case (k)
      4'd1: return (t == 0) ? br : fall;
      4'd2: return (t != 0) ? br : fall;
      4'd3: return f ? br : fall;
      4'd4: return !f ? br : fall;
      4'd5, 4'd6: return jp;
      4'd7, 4'd8: return r;
      default: return fall;
    endcase
  endfunction

  task automatic run(input string req, input logic [3:0] k, input logic [31:0] p,
      input logic [25:0] o, input logic [31:0] t, input logic [31:0] r, input logic f,
      input logic exp_taken, input logic exp_link, input logic exp_mis);
    @(negedge clk);
    in_valid = 1'b1; kind = k; pc = p; offset = o; test_val = t;
    reg_target = r; fp_flag = f;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " out_valid"}, {31'd0, out_valid}, 32'd1);
    chk({req, " next_pc"}, next_pc, want_pc(k, p, o, t, r, f));
    chk({req, " taken"}, {31'd0, taken}, {31'd0, exp_taken});
    chk({req, " link_we"}, {31'd0, link_we}, {31'd0, exp_link});
    chk({req, " misaligned"}, {31'd0, misaligned}, {31'd0, exp_mis});
    if (exp_link) begin
      chk({req, " link_idx"}, {27'd0, link_idx}, 32'd31);
      chk({req, " link_val"}, link_val, p + 32'd4);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; pc = '0; kind = '0; offset = '0;
    test_val = '0; reg_target = '0; fp_flag = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", {31'd0, out_valid}, 32'd0);
    chk("R1 taken in reset", {31'd0, taken}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
    chk("R1 flags after reset", {29'd0, taken, link_we, misaligned}, 32'd0);
  endtask

  task automatic t_seq();
    run("R2 seq", 4'd0, 32'h0000_1000, 26'h3FF_FFFF, 32'd0, 32'h3, 1'b1, 1'b0, 1'b0, 1'b0);
    run("R2 unknown kind", 4'hF, 32'h0000_1000, 26'h000_0040, 32'd0, 32'h3, 1'b1, 1'b0, 1'b0, 1'b0);
    run("R12 wrap", 4'd0, 32'hFFFF_FFFC, 26'd0, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reg_branch();
    run("R3 bz taken back", 4'd1, 32'h0000_2000, 26'h000_FFF0, 32'd0, 32'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    run("R10 bz not taken", 4'd1, 32'h0000_2000, 26'h000_FFF0, 32'd5, 32'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    run("R3 bz upper offset bits ignored", 4'd1, 32'h0000_2000, 26'h3FF_0010, 32'd0, 32'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    run("R4 bnz taken", 4'd2, 32'h0000_3000, 26'h000_0100, 32'h8000_0000, 32'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    run("R4 R10 bnz not taken", 4'd2, 32'h0000_3000, 26'h000_0100, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_fp_branch();
    run("R5 bft taken", 4'd3, 32'h0000_4000, 26'h000_8000, 32'd7, 32'd0, 1'b1, 1'b1, 1'b0, 1'b0);
    run("R5 bft not taken", 4'd3, 32'h0000_4000, 26'h000_8000, 32'd7, 32'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    run("R5 bff taken", 4'd4, 32'h0000_4000, 26'h000_0020, 32'd0, 32'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    run("R5 bff not taken", 4'd4, 32'h0000_4000, 26'h000_0020, 32'd0, 32'd0, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_jumps();
    run("R6 jump negative", 4'd5, 32'h0400_0000, 26'h200_0000, 32'd0, 32'h1, 1'b0, 1'b1, 1'b0, 1'b0);
    run("R6 R9 jump odd offset", 4'd5, 32'h0000_0100, 26'h001_0001, 32'd0, 32'h2, 1'b0, 1'b1, 1'b0, 1'b0);
    run("R7 jump link", 4'd6, 32'h0010_0000, 26'h000_0400, 32'd0, 32'd0, 1'b0, 1'b1, 1'b1, 1'b0);
    run("R8 reg jump", 4'd7, 32'h0000_5000, 26'h000_0444, 32'd0, 32'h8000_0100, 1'b0, 1'b1, 1'b0, 1'b0);
    run("R8 R9 reg jump link unaligned", 4'd8, 32'h0000_6000, 26'd0, 32'd0, 32'h0000_1002, 1'b0, 1'b1, 1'b1, 1'b1);
    run("R9 reg jump unaligned", 4'd7, 32'h0000_6000, 26'd0, 32'd0, 32'h0000_1001, 1'b0, 1'b1, 1'b0, 1'b1);
    run("R12 jump wrap", 4'd5, 32'hFFFF_FFF8, 26'h000_0010, 32'd0, 32'd0, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_idle();
    @(negedge clk);
    in_valid = 1'b0; kind = 4'd8; reg_target = 32'h3; pc = 32'h100;
    @(negedge clk);
    chk("R11 idle out_valid", {31'd0, out_valid}, 32'd0);
    chk("R11 idle flags", {29'd0, taken, link_we, misaligned}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_seq();
    t_reg_branch();
    t_fp_branch();
    t_jumps();
    t_idle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule